// File: doc/BRIEF.md
# Iterative 384-bit Permutation Core

This block runs a fixed 24-round permutation over a 384-bit state. The state is a matrix of twelve 32-bit words in three rows and four columns. Every round does two things. First it pushes each of the four 96-bit columns through a rotate-and-mix SP-box. Then it may reshuffle the words of row 0, depending on the round number. Rounds are numbered 24 down to 1. The two low bits of the round number choose one of three linear steps:

- exchange adjacent pairs of row-0 words and add a round-dependent constant;
- exchange the two halves of row 0;
- leave row 0 unchanged.

A single register holds the input, the working state and the result. A build-time parameter sets how many rounds are chained as combinational logic between clock edges. The parameter trades clock period against latency: one operation takes 24 divided by that count cycles. A host pulses `start` with the input word while the core is idle. It then waits for the one-cycle `done` pulse and reads `dout`, which holds the result until the next accepted start.

Top module: `perm384_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` and `done` are low and `dout` is all zero.
- R2: A `start` seen at a clock edge while `busy` is low loads `din` into the state and raises `busy` after that edge.
- R3: `done` goes high exactly 24/ROUNDS_PER_CLK clock edges after the edge that accepted `start`.
- R4: `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R5: A `start` seen while `busy` is high has no effect: neither the result nor the finishing cycle of the running operation changes.
- R6: While `busy` is low and no `start` is accepted, `dout` keeps its value, however `din` changes.
- R7: In each round every column j gets the SP-box. Take x = row-0 word rotated left by 24, y = row-1 word rotated left by 9, and z = row-2 word. The new row 2 is x ^ (z<<1) ^ ((y&z)<<2). The new row 1 is y ^ x ^ ((x|z)<<1). The new row 0 is z ^ y ^ ((x&y)<<3). The shifts are non-cyclic and all three outputs use the pre-round words.
- R8: After the SP-box, in rounds whose number r satisfies r mod 4 = 0, row-0 words 0/1 and 2/3 are exchanged. Then 0x9e377900 XOR r is XORed into row-0 word 0.
- R9: After the SP-box, in rounds with r mod 4 = 2, row-0 words 0/2 and 1/3 are exchanged. Odd rounds have no linear step.
- R10: The word in row i, column j occupies bits [(4*i+j)*32 +: 32] of `din` and `dout`. Byte b of the 48-byte state occupies bits [8*b +: 8], which makes each word little-endian.
- R11: A `start` given in the same cycle as `done` is accepted, so operations can run back to back without an idle cycle.
- R12: ROUNDS_PER_CLK may be 1, 2, 3, 4, 6 or 8. Every legal value yields the same result, and only the latency changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation on `din` (ignored while busy) |
| din | input | 384 | Input state, word (i,j) at bits [(4i+j)*32 +: 32] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the last round has been applied |
| dout | output | 384 | Registered state; the result once `done` has pulsed |

## Verification
The all-zero input is the first target. A core that dropped or misplaced the round constant, or picked the wrong rounds for the exchange steps, would give a wrong nonzero word there. A byte-counting input catches row/column or byte-order mix-ups. A restart attempt in the middle of an operation exposes a core that reloads the state or restarts its counter: the result or the finishing cycle would move. A start in the `done` cycle catches a core that needs an idle cycle between operations. A second core built with three rounds per clock must give identical results in eight cycles, which catches a mistake in stage-by-stage round numbering.

// File: rtl/perm384_pkg.sv
package perm384_pkg;
  localparam int WORD_W  = 32;
  localparam int N_ROWS  = 3;
  localparam int N_COLS  = 4;
  localparam int STATE_W = WORD_W * N_ROWS * N_COLS;
  localparam int N_ROUNDS = 24;
  localparam int RND_W   = $clog2(N_ROUNDS + 1);
  localparam logic [WORD_W-1:0] RC_BASE = 32'h9e377900;

  // Position of word (row, col) in the flat state vector
  function automatic int word_lsb(input int row, input int col);
    return (row * N_COLS + col) * WORD_W;
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int k);
    return (v << k) | (v >> (WORD_W - k));
  endfunction
endpackage

// File: rtl/perm384_spbox.sv
module perm384_spbox
  import perm384_pkg::*;
(
  input  logic [WORD_W-1:0] top_i,
  input  logic [WORD_W-1:0] mid_i,
  input  logic [WORD_W-1:0] bot_i,
  output logic [WORD_W-1:0] top_o,
  output logic [WORD_W-1:0] mid_o,
  output logic [WORD_W-1:0] bot_o
);
  logic [WORD_W-1:0] x, y, z;

  always_comb begin
    x = rotl(top_i, 24);
    y = rotl(mid_i, 9);
    z = bot_i;
    // T-function followed by exchange of the outer words
    bot_o = x ^ (z << 1) ^ ((y & z) << 2);
    mid_o = y ^ x ^ ((x | z) << 1);
    top_o = z ^ y ^ ((x & y) << 3);
  end
endmodule

// File: rtl/perm384_round.sv
module perm384_round
  import perm384_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  logic [RND_W-1:0]   rnd_i,
  output logic [STATE_W-1:0] st_o
);
  logic [STATE_W-1:0] mixed;

  genvar j;
  generate
    for (j = 0; j < N_COLS; j++) begin : g_col
      perm384_spbox u_box (
        .top_i (st_i[word_lsb(0, j) +: WORD_W]),
        .mid_i (st_i[word_lsb(1, j) +: WORD_W]),
        .bot_i (st_i[word_lsb(2, j) +: WORD_W]),
        .top_o (mixed[word_lsb(0, j) +: WORD_W]),
        .mid_o (mixed[word_lsb(1, j) +: WORD_W]),
        .bot_o (mixed[word_lsb(2, j) +: WORD_W])
      );
    end
  endgenerate

  logic [WORD_W-1:0] w0, w1, w2, w3;

  always_comb begin
    w0 = mixed[word_lsb(0, 0) +: WORD_W];
    w1 = mixed[word_lsb(0, 1) +: WORD_W];
    w2 = mixed[word_lsb(0, 2) +: WORD_W];
    w3 = mixed[word_lsb(0, 3) +: WORD_W];
    st_o = mixed;
    unique case (rnd_i[1:0])
      2'b00: begin
        st_o[word_lsb(0, 0) +: WORD_W] = w1 ^ RC_BASE ^ WORD_W'(rnd_i);
        st_o[word_lsb(0, 1) +: WORD_W] = w0;
        st_o[word_lsb(0, 2) +: WORD_W] = w3;
        st_o[word_lsb(0, 3) +: WORD_W] = w2;
      end
      2'b10: begin
        st_o[word_lsb(0, 0) +: WORD_W] = w2;
        st_o[word_lsb(0, 1) +: WORD_W] = w3;
        st_o[word_lsb(0, 2) +: WORD_W] = w0;
        st_o[word_lsb(0, 3) +: WORD_W] = w1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/perm384_core.sv
module perm384_core
  import perm384_pkg::*;
#(
  parameter int ROUNDS_PER_CLK = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] din,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] dout
);
  localparam logic [RND_W-1:0] STEP = RND_W'(ROUNDS_PER_CLK);

  logic [STATE_W-1:0] state_q;
  logic [RND_W-1:0]   rnd_q;
  logic [STATE_W-1:0] stage [0:ROUNDS_PER_CLK];

  assign stage[0] = state_q;

  genvar i;
  generate
    for (i = 0; i < ROUNDS_PER_CLK; i++) begin : g_stage
      logic [RND_W-1:0] rnd_here;
      assign rnd_here = rnd_q - RND_W'(i);
      perm384_round u_round (
        .st_i  (stage[i]),
        .rnd_i (rnd_here),
        .st_o  (stage[i+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      rnd_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        state_q <= stage[ROUNDS_PER_CLK];
        rnd_q   <= rnd_q - STEP;
        if (rnd_q == STEP) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        state_q <= din;
        rnd_q   <= RND_W'(N_ROUNDS);
        busy    <= 1'b1;
      end
    end
  end

  assign dout = state_q;
endmodule

// File: rtl/perm384_core_chk.sv
module perm384_core_chk
  import perm384_pkg::*;
#(
  parameter int ROUNDS_PER_CLK = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] dout
);
  localparam int N_CYC = N_ROUNDS / ROUNDS_PER_CLK;

  logic [5:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (start && !busy) cyc <= '0;
    else if (busy) cyc <= cyc + 6'd1;
  end

  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == 6'(N_CYC)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_busy_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc != 6'(N_CYC - 1)) |=> busy);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(dout) && !busy));
endmodule

bind perm384_core perm384_core_chk #(.ROUNDS_PER_CLK(ROUNDS_PER_CLK)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .dout  (dout)
);

// File: tb/tb_perm384_core.sv
`timescale 1ns/1ps
module tb_perm384_core;
  localparam int RPC   = 2;
  localparam int NCYC  = 24 / RPC;
  localparam int RPC_B = 3;
  localparam int NCYC_B = 24 / RPC_B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [383:0] din = '0;
  logic busy, done, busy_b, done_b;
  logic [383:0] dout, dout_b;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  perm384_core #(.ROUNDS_PER_CLK(RPC)) dut (
    .clk(clk), .rst(rst), .start(start), .din(din),
    .busy(busy), .done(done), .dout(dout));

  perm384_core #(.ROUNDS_PER_CLK(RPC_B)) dut_b (
    .clk(clk), .rst(rst), .start(start), .din(din),
    .busy(busy_b), .done(done_b), .dout(dout_b));

  // Behavioural permutation model working on a word array
  function automatic logic [383:0] ref_perm(input logic [383:0] v);
    bit [31:0] s [3][4];
    bit [31:0] a, b, c, t;
    logic [383:0] r;
    for (int row = 0; row < 3; row++)
      for (int col = 0; col < 4; col++)
        for (int by = 0; by < 4; by++)
          s[row][col][8*by +: 8] = v[8*(4*(4*row+col)+by) +: 8];
    for (int rn = 24; rn >= 1; rn--) begin
      for (int col = 0; col < 4; col++) begin
        a = {s[0][col][7:0], s[0][col][31:8]};
        b = {s[1][col][22:0], s[1][col][31:23]};
        c = s[2][col];
        s[2][col] = a ^ (c << 1) ^ ((b & c) << 2);
        s[1][col] = b ^ a ^ ((a | c) << 1);
        s[0][col] = c ^ b ^ ((a & b) << 3);
      end
      if (rn % 4 == 0) begin
        t = s[0][0]; s[0][0] = s[0][1]; s[0][1] = t;
        t = s[0][2]; s[0][2] = s[0][3]; s[0][3] = t;
        s[0][0] = s[0][0] ^ 32'h9e377900 ^ rn;
      end else if (rn % 4 == 2) begin
        t = s[0][0]; s[0][0] = s[0][2]; s[0][2] = t;
        t = s[0][1]; s[0][1] = s[0][3]; s[0][3] = t;
      end
    end
    for (int row = 0; row < 3; row++)
      for (int col = 0; col < 4; col++)
        for (int by = 0; by < 4; by++)
          r[8*(4*(4*row+col)+by) +: 8] = s[row][col][8*by +: 8];
    return r;
  endfunction

  // Cycle-level model of the default-configuration core
  logic m_busy = 1'b0, m_done = 1'b0;
  logic [383:0] m_out = '0, m_pend = '0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_out = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == NCYC) begin
          m_busy = 1'b0; m_done = 1'b1; m_out = ref_perm(m_pend);
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0; m_pend = din;
      end
    end
  end

  task automatic check1(input bit ok, input string req, input logic [383:0] act,
                        input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R2, R3, R4, R5, R6, R11)
  always @(negedge clk) begin
    if (!rst) begin
      check1(busy === m_busy, "R2 R5 busy", 384'(busy), 384'(m_busy));
      check1(done === m_done, "R3 R4 R11 done", 384'(done), 384'(m_done));
      if (!m_busy) check1(dout === m_out, "R6 R7 dout", dout, m_out);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Start one operation on both cores and track latency and result of each
  task automatic run_op(input logic [383:0] v, input string tag, input bit poke);
    int k, ka, kb;
    logic [383:0] ra, rb, exp;
    exp = ref_perm(v);
    start = 1'b1; din = v;
    @(negedge clk);
    start = 1'b0; din = ~v;
    k = 0; ka = -1; kb = -1;
    while ((ka < 0 || kb < 0) && k < 40) begin
      if (poke && k == 3) begin start = 1'b1; din = {12{32'h5a5a0ff0}}; end
      else start = 1'b0;
      @(negedge clk);
      k++;
      if (done && ka < 0) begin ka = k; ra = dout; end
      if (done_b && kb < 0) begin kb = k; rb = dout_b; end
    end
    start = 1'b0;
    check1(ka == NCYC, {tag, " R3 latency"}, 384'(ka), 384'(NCYC));
    check1(ra === exp, {tag, " R7 R8 R9 R10 result"}, ra, exp);
    check1(kb == NCYC_B, {tag, " R12 latency"}, 384'(kb), 384'(NCYC_B));
    check1(rb === exp, {tag, " R12 result"}, rb, exp);
    @(negedge clk);
  endtask

  initial begin
    logic [383:0] v, held;
    repeat (3) @(negedge clk);
    check1(busy === 1'b0 && done === 1'b0, "R1 flags in reset", 384'({busy, done}), '0);
    rst = 1'b0;
    @(negedge clk);
    check1(dout === '0 && !busy && !done, "R1 after reset", dout, '0);

    run_op('0, "zero", 1'b0);

    for (int b = 0; b < 48; b++) v[8*b +: 8] = 8'(b);
    run_op(v, "bytes", 1'b0);

    run_op({12{32'hffffffff}}, "ones", 1'b0);

    // R5: restart attempt in the middle of an operation is ignored
    run_op({32'h01234567, 32'h89abcdef, {10{32'hdeadbeef}}}, "R5 poke", 1'b1);

    // R6: idle with changing din, no start
    held = dout;
    for (int n = 0; n < 5; n++) begin
      din = {12{32'(n * 32'h11111111)}};
      @(negedge clk);
    end
    check1(dout === held && !busy, "R6 idle hold", dout, held);

    // R11: start in the done cycle
    v = {384{1'b1}} >> 7;
    start = 1'b1; din = v;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; din = ~v;
    check1(!busy, "R11 idle at done", 384'(busy), '0);
    @(negedge clk);
    start = 1'b0;
    check1(busy === 1'b1, "R11 back-to-back accepted", 384'(busy), 384'(1));
    for (int n = 0; n < NCYC; n++) @(negedge clk);
    check1(done && dout === ref_perm(~v), "R11 second result", dout, ref_perm(~v));
    repeat (NCYC_B + 4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule